// File: doc/BRIEF.md
# Programmable Period Interval Timer

This block is a periodic interrupt source that sits on a simple 32-bit memory-mapped bus. Software writes a 3-bit period code into a single configuration word. The block then counts clock cycles and emits an interrupt request every time the selected period elapses. It keeps doing so without any further software action.

The available periods form a fixed, non-linear set of eight values, running from half a second up to one minute. The number of cycles per period comes from a clock-frequency parameter. A bench can therefore use a tiny frequency and see every period within a few thousand cycles.

Writing the configuration word restarts the count, so the new period is measured from the write. Masking of the request is left to the processor that receives it.

Top module: `interval_timer`

## Requirements
- R1: The configuration word answers to byte addresses 0xFFFFFF10 through 0xFFFFFF13, matched on address bits [31:2]. A read at any other address returns zero.
- R2: After reset the stored code is 0. The first request rises exactly CLK_HZ/2 cycles after reset is released.
- R3: Let H be CLK_HZ/2 cycles, one half-second. The codes map to periods as follows: code 0 is 1·H, code 1 is 2·H, code 2 is 3·H, code 3 is 4·H, code 4 is 10·H, code 5 is 20·H, code 6 is 60·H and code 7 is 120·H.
- R4: Requests repeat once per selected period for as long as the code is left alone.
- R5: An accepted write clears the count. The next request rises exactly one full new period after the clock edge that took the write.
- R6: Only write-data bits [2:0] are stored. Read-data bits [31:3] are always zero.
- R7: Each request is a pulse exactly one clock cycle wide.
- R8: A read at the register's address returns the stored code combinationally, in the same cycle the read strobe is high.
- R9: When a write lands on the same edge as a period expiry, the write wins. No request is issued on that edge, and the new period starts from the write.
- R10: A write to any address outside the register's word changes neither the stored code nor the running count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 32 | Byte address of the bus access |
| busWrEn | input | 1 | Write strobe, one cycle per word write |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Read data, valid in the same cycle as busRdEn |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
A configuration write and a period expiry can fall on the same clock edge. In that case the write's clear of the count competes with the expiry's wrap and pulse.

The bench provokes this collision on purpose. It first locks onto a request pulse. It then counts cycles forward so that a write of the shortest code lands exactly on the edge where the next expiry is due.

The outcome is judged in two steps. The request must stay low after that edge. The following request must then arrive one full period after the write, not one period after the suppressed expiry.

// File: rtl/interval_timer_pkg.sv
package interval_timer_pkg;

  localparam int CODE_W = 3;
  localparam int NUM_CODES = 1 << CODE_W;

  typedef struct packed {
    logic              cfgLoad;
    logic [CODE_W-1:0] cfgCode;
  } tmrStrobe_t;

  // Period length for each code, in half-second steps.
  function automatic int unsigned halfSteps(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 3;
      3'd3:    return 4;
      3'd4:    return 10;
      3'd5:    return 20;
      3'd6:    return 60;
      default: return 120;
    endcase
  endfunction

endpackage

// File: rtl/interval_timer_ctrl.sv
module interval_timer_ctrl
  import interval_timer_pkg::*;
#(
  parameter logic [31:0] CFG_ADDR = 32'hFFFF_FF10
) (
  input  logic [31:0]       busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  input  logic              busRdEn,
  input  logic [CODE_W-1:0] curCode,
  output tmrStrobe_t        strobe,
  output logic [31:0]       busRdData
);

  logic addrHit;
  logic unusedBits;

  assign addrHit    = (busAddr[31:2] == CFG_ADDR[31:2]);
  assign unusedBits = ^{busAddr[1:0], busWrData[31:CODE_W]};

  always_comb begin
    strobe.cfgLoad = busWrEn && addrHit;
    strobe.cfgCode = busWrData[CODE_W-1:0];
  end

  always_comb begin
    busRdData = '0;
    if (busRdEn && addrHit) busRdData[CODE_W-1:0] = curCode;
  end

endmodule

// File: rtl/interval_timer_dp.sv
module interval_timer_dp
  import interval_timer_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 100_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strobe,
  output logic [CODE_W-1:0] curCode,
  output logic              irq
);

  localparam longint unsigned HALF_TICKS = CLK_HZ / 2;
  localparam longint unsigned MAX_TICKS  = 120 * HALF_TICKS;
  localparam int CW = $clog2(MAX_TICKS + 1);
  localparam logic [CW-1:0] HALF_CW = CW'(HALF_TICKS);

  logic [CW-1:0] lastTable [NUM_CODES];
  logic [CW-1:0] cnt;
  logic [CODE_W-1:0] codeQ;
  logic expire;

  // One terminal value per code, each computed at elaboration.
  for (genvar g = 0; g < NUM_CODES; g++) begin : g_period
    assign lastTable[g] = CW'(halfSteps(CODE_W'(g))) * HALF_CW - CW'(1);
  end

  assign expire  = (cnt == lastTable[codeQ]);
  assign curCode = codeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      codeQ <= '0;
      irq   <= 1'b0;
    end else if (strobe.cfgLoad) begin
      cnt   <= '0;
      codeQ <= strobe.cfgCode;
      irq   <= 1'b0;
    end else if (expire) begin
      cnt <= '0;
      irq <= 1'b1;
    end else begin
      cnt <= cnt + CW'(1);
      irq <= 1'b0;
    end
  end

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import interval_timer_pkg::*;
#(
  parameter longint unsigned CLK_HZ   = 100_000_000,
  parameter logic [31:0]     CFG_ADDR = 32'hFFFF_FF10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] busAddr,
  input  logic        busWrEn,
  input  logic [31:0] busWrData,
  input  logic        busRdEn,
  output logic [31:0] busRdData,
  output logic        irq
);

  tmrStrobe_t        strobe;
  logic [CODE_W-1:0] curCode;

  interval_timer_ctrl #(.CFG_ADDR(CFG_ADDR)) ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdEn(busRdEn), .curCode(curCode), .strobe(strobe),
    .busRdData(busRdData)
  );

  interval_timer_dp #(.CLK_HZ(CLK_HZ)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curCode(curCode), .irq(irq)
  );

endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter logic [31:0] CFG_ADDR = 32'hFFFF_FF10
) (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] busAddr,
  input logic        busWrEn,
  input logic [31:0] busWrData,
  input logic        busRdEn,
  input logic [31:0] busRdData,
  input logic        irq
);

  logic hit, wrHit, rdHit;
  logic unusedChk;

  assign hit       = (busAddr[31:2] == CFG_ADDR[31:2]);
  assign wrHit     = busWrEn && hit;
  assign rdHit     = busRdEn && hit;
  assign unusedChk = ^{busAddr[1:0], busWrData[31:3]};

  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R9
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrHit |=> !irq);

  // R6
  rd_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdHit |-> busRdData[31:3] == 29'd0);

  // R1
  rd_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && !hit) |-> busRdData == 32'd0);

  // R8
  rd_fresh_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit ##1 rdHit) |-> busRdData[2:0] == $past(busWrData[2:0]));

endmodule

bind interval_timer interval_timer_chk #(.CFG_ADDR(CFG_ADDR)) chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData), .irq(irq)
);

// File: tb/interval_timer_test.sv
module interval_timer_test;

  localparam longint unsigned HZ = 20;
  localparam int H = 10;
  localparam logic [31:0] REG = 32'hFFFF_FF10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic irq;

  int tests = 0;
  int failed = 0;

  interval_timer #(.CLK_HZ(HZ)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData), .irq(irq)
  );

  always #4 clk = ~clk;

  function automatic int expTicks(input int code);
    int steps [8] = '{1, 2, 3, 4, 10, 20, 60, 120};
    return steps[code] * H;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic waitIrq(output int n);
    n = 0;
    while (!irq && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic testReset();
    logic [31:0] d;
    int n;
    busRead(REG, d);
    check("R2 code during reset", d, 0);
    check("R2 irq low in reset", irq, 0);
    @(negedge clk);
    rstN = 1'b1;
    waitIrq(n);
    check("R2 first period after reset", n, H);
  endtask

  task automatic testRepeat();
    int n;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R7 pulse width", irq, 0);
      waitIrq(n);
      check("R4 repeat period", n, H - 1);
    end
  endtask

  task automatic testSweep();
    logic [31:0] d;
    int n;
    for (int c = 0; c < 8; c++) begin
      busWrite(REG, 32'(c));
      waitIrq(n);
      check("R3 R5 period after write", n, expTicks(c));
      busRead(REG, d);
      check("R8 readback", d, c);
    end
  endtask

  task automatic testUpper();
    logic [31:0] d;
    busWrite(REG, 32'hFFFF_FFFE);
    busRead(REG, d);
    check("R6 upper bits dropped", d, 6);
  endtask

  task automatic testAlias();
    logic [31:0] d;
    busWrite(32'hFFFF_FF12, 32'd2);
    busRead(32'hFFFF_FF13, d);
    check("R1 byte alias", d, 2);
    busRead(32'hFFFF_FF14, d);
    check("R1 miss reads zero", d, 0);
  endtask

  task automatic testMiss();
    logic [31:0] d;
    int n;
    busWrite(REG, 32'd0);
    waitIrq(n);
    busWrite(32'hFFFF_FF14, 32'd7);
    waitIrq(n);
    check("R10 count not cleared", n, H - 2);
    busWrite(32'hFFFF_FF0C, 32'd5);
    busRead(REG, d);
    check("R10 code kept", d, 0);
  endtask

  task automatic testCollide();
    int n;
    waitIrq(n);
    repeat (8) @(negedge clk);
    busWrite(REG, 32'd0);
    check("R9 no pulse on collision", irq, 0);
    waitIrq(n);
    check("R9 period from write", n, H);
  endtask

  task automatic testMidReset();
    logic [31:0] d;
    busWrite(REG, 32'd3);
    repeat (5) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    busRead(REG, d);
    check("R2 code after reset", d, 0);
  endtask

  initial begin
    #(8 * 150000);
    tests++;
    failed++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    testReset();
    testRepeat();
    testSweep();
    testUpper();
    testAlias();
    testMiss();
    testCollide();
    testMidReset();
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule